// File: doc/BRIEF.md
# Serial Peripheral Master with Selectable Transfer Direction

This block is a single-channel serial master. It moves one word at a time over a serial clock, a data-out line, a data-in line and an active-low chip select. A host loads words through a transmit holding register and takes received words from a receive register. Level flags, interrupt lines and DMA request lines report the state of both registers.

A two-bit direction field selects one of three behaviours. In full duplex, every word written by the host is exchanged for one word from the slave. In transmit-only operation, received words are discarded into an always-overwritten receive register. Receive-related requests are suppressed and overflow cannot occur. In receive-only operation, the master keeps clocking words in whenever the receive register is empty and needs no host writes. It sends the most recent transmit value on data-out, and transmit-related requests are suppressed. An end-of-transfer flag marks that the last word has completed.

Serial clock idles low. Data changes on the falling edge and is sampled on the rising edge, most significant bit first.

Top module: `spi_mode_master`

## Requirements
- R1: In full-duplex (mode 00) a write to the transmit register starts one word exchange; afterwards `rx_data` holds the word the slave sent and the slave holds the written word, bits sent most significant first. With no pending write the chip select stays high.
- R2: Mode encoding is 00 full duplex, 01 receive-only, 10 transmit-only; 11 behaves exactly as 00.
- R3: In transmit-only (mode 10) no transfer starts until the host writes the transmit register.
- R4: In transmit-only, a completed word replaces `rx_data` even when `rx_full` is already set, and `rx_ovf` never becomes 1.
- R5: In transmit-only, `irq_rx_full` and `dma_rd_req` stay 0 even while `rx_full` is 1.
- R6: In full duplex, a word that completes while `rx_full` is 1 sets `rx_ovf` and leaves `rx_data` unchanged; a `rx_rd` pulse clears both `rx_full` and `rx_ovf`.
- R7: In receive-only (mode 01) a transfer starts without any host write whenever `rx_full` is 0 and never while it is 1. Data-out carries the last written transmit word, which is all zeros if none was written since reset. `irq_tx_empty` and `dma_wr_req` stay 0.
- R8: `eot` is 0 after reset, drops to 0 when a transfer starts and becomes 1 when the transfer completes.
- R9: Chip select falls one system clock before the first rising serial clock edge and rises one system clock after the last falling edge. The serial clock is low whenever chip select is high.
- R10: Outside the suppressed cases, `irq_tx_empty` and `dma_wr_req` equal the inverse of `tx_full`, and `irq_rx_full` and `dma_rd_req` equal `rx_full`.
- R11: After reset `cs_n`=1, `sclk`=0, `tx_full`=0, `rx_full`=0, `rx_ovf`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Transfer direction: 00/11 full duplex, 01 receive-only, 10 transmit-only |
| tx_data | input | WORD_W | Word to transmit |
| tx_wr | input | 1 | Write strobe for the transmit register |
| rx_data | output | WORD_W | Last stored received word |
| rx_rd | input | 1 | Read strobe; empties the receive register and clears overflow |
| tx_full | output | 1 | Transmit register holds an unsent word |
| rx_full | output | 1 | Receive register holds an unread word |
| rx_ovf | output | 1 | A word was lost because the receive register was full |
| eot | output | 1 | Last transfer has completed |
| irq_tx_empty | output | 1 | Interrupt: transmit register may be refilled |
| irq_rx_full | output | 1 | Interrupt: receive register has data |
| dma_wr_req | output | 1 | DMA request to write the transmit register |
| dma_rd_req | output | 1 | DMA request to read the receive register |
| sclk | output | 1 | Serial clock, idles low |
| mosi | output | 1 | Serial data out |
| cs_n | output | 1 | Chip select, active low |
| miso | input | 1 | Serial data in |

## Verification
The assertions assume that the host keeps `mode` steady while a word is on the wire. They also assume that `rx_rd` is not pulsed in the same cycle that a word completes, because the properties reason about a single owner of `rx_full` per cycle. The stimulus changes `mode` only while the chip select is high and no start condition is met. It issues reads only between transfers. The slave model shifts on the serial clock edges the master defines, so `miso` is stable at every sampling edge.

// File: rtl/spi_mode_master.sv
module spi_mode_master #(
  parameter int WORD_W   = 8,
  parameter int HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              tx_wr,
  output logic [WORD_W-1:0] rx_data,
  input  logic              rx_rd,
  output logic              tx_full,
  output logic              rx_full,
  output logic              rx_ovf,
  output logic              eot,
  output logic              irq_tx_empty,
  output logic              irq_rx_full,
  output logic              dma_wr_req,
  output logic              dma_rd_req,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  input  logic              miso
);

  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BW = $clog2(WORD_W + 1);
  localparam logic [CW-1:0] HALF_LAST = CW'(HALF_DIV - 1);
  localparam logic [BW-1:0] LAST_BIT  = BW'(WORD_W);

  typedef enum logic [1:0] {S_IDLE, S_LEAD, S_SHIFT, S_TRAIL} st_t;

  st_t               st;
  logic [CW-1:0]     cnt;
  logic [BW-1:0]     bcnt;
  logic [WORD_W-1:0] shreg, tx_buf;
  logic              rbit;

  wire m_ro  = (mode == 2'b01);
  wire m_to  = (mode == 2'b10);
  wire start = (st == S_IDLE) && (m_ro ? !rx_full : tx_full);
  wire done  = (st == S_TRAIL);
  wire keep_full = rx_full && !rx_rd;

  assign mosi         = !cs_n && shreg[WORD_W-1];
  assign irq_tx_empty = !tx_full && !m_ro;
  assign dma_wr_req   = !tx_full && !m_ro;
  assign irq_rx_full  = rx_full && !m_to;
  assign dma_rd_req   = rx_full && !m_to;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_IDLE;
      cs_n  <= 1'b1;
      sclk  <= 1'b0;
      cnt   <= '0;
      bcnt  <= '0;
      shreg <= '0;
      rbit  <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          shreg <= tx_buf;
          cs_n  <= 1'b0;
          st    <= S_LEAD;
        end
        S_LEAD: begin
          sclk <= 1'b1;
          rbit <= miso;
          bcnt <= BW'(1);
          cnt  <= '0;
          st   <= S_SHIFT;
        end
        S_SHIFT: begin
          if (cnt == HALF_LAST) begin
            cnt  <= '0;
            sclk <= !sclk;
            if (!sclk) begin
              rbit <= miso;
              bcnt <= bcnt + BW'(1);
            end else begin
              shreg <= {shreg[WORD_W-2:0], rbit};
              if (bcnt == LAST_BIT) st <= S_TRAIL;
            end
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
        default: begin
          cs_n <= 1'b1;
          st   <= S_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_buf  <= '0;
      tx_full <= 1'b0;
      eot     <= 1'b0;
      rx_data <= '0;
      rx_full <= 1'b0;
      rx_ovf  <= 1'b0;
    end else begin
      if (tx_wr) tx_buf <= tx_data;
      if (tx_wr)      tx_full <= 1'b1;
      else if (start) tx_full <= 1'b0;
      if (start)     eot <= 1'b0;
      else if (done) eot <= 1'b1;
      if (rx_rd) begin
        rx_full <= 1'b0;
        rx_ovf  <= 1'b0;
      end
      if (done) begin
        if (m_to || !keep_full) begin
          rx_data <= shreg;
          rx_full <= 1'b1;
        end else begin
          rx_ovf <= 1'b1;
        end
      end
    end
  end

  p_cs_lead_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |=> $rose(sclk));
  p_cs_trail_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sclk) && bcnt == LAST_BIT) |=> $rose(cs_n));
  p_sclk_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk);
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (m_to && !rx_ovf) |=> !rx_ovf);
  p_rx_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (m_to && rx_full) |-> (!irq_rx_full && !dma_rd_req));
  p_tx_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ro && !tx_full) |-> (!irq_tx_empty && !dma_wr_req));
  p_ro_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (m_ro && rx_full && !rx_rd && st == S_IDLE) |=> cs_n);
  p_wait_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!m_ro && !tx_full && st == S_IDLE) |=> cs_n);
  p_eot_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n) |-> eot);

endmodule

// File: tb/test_spi_mode_master.sv
module test_spi_mode_master;
  localparam int W = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic [W-1:0] tx_data = '0;
  logic tx_wr = 1'b0, rx_rd = 1'b0;
  logic [W-1:0] rx_data;
  logic tx_full, rx_full, rx_ovf, eot;
  logic irq_tx_empty, irq_rx_full, dma_wr_req, dma_rd_req;
  logic sclk, mosi, cs_n, miso;

  int n_run = 0, n_fail = 0, n_xfer = 0;
  bit armed = 1'b0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] slv_sh = '0, slv_sent = '0;
  logic cap = 1'b0;

  always #4 clk = ~clk;

  spi_mode_master #(.WORD_W(W), .HALF_DIV(2)) i_spi_mode_master (
    .clk(clk), .rst_n(rst_n), .mode(mode), .tx_data(tx_data), .tx_wr(tx_wr),
    .rx_data(rx_data), .rx_rd(rx_rd), .tx_full(tx_full), .rx_full(rx_full),
    .rx_ovf(rx_ovf), .eot(eot), .irq_tx_empty(irq_tx_empty),
    .irq_rx_full(irq_rx_full), .dma_wr_req(dma_wr_req), .dma_rd_req(dma_rd_req),
    .sclk(sclk), .mosi(mosi), .cs_n(cs_n), .miso(miso));

  assign miso = slv_sh[W-1];

  always @(negedge cs_n) begin
    slv_sh   = 8'h5A + 8'(n_xfer * 8'h37);
    slv_sent = slv_sh;
    n_xfer++;
  end
  always @(posedge sclk) cap = mosi;
  always @(negedge sclk) slv_sh = {slv_sh[W-2:0], cap};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(posedge cs_n);
      if (!armed) continue;
      if (exp_q.size() == 0) chk("R1 unexpected transfer", 1, 0);
      else chk("R1 slave received word", slv_sh, exp_q.pop_front());
    end
  end

  task automatic do_write(input logic [W-1:0] d);
    exp_q.push_back(d);
    @(negedge clk); tx_wr = 1'b1; tx_data = d;
    @(negedge clk); tx_wr = 1'b0;
  endtask

  task automatic do_read();
    @(negedge clk); rx_rd = 1'b1;
    @(negedge clk); rx_rd = 1'b0;
  endtask

  task automatic wait_done();
    @(posedge cs_n);
    @(negedge clk);
  endtask

  task automatic idle_check(input string req, input int cycles);
    int lows = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!cs_n) lows++;
    end
    chk(req, lows, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [W-1:0] held;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    armed = 1'b1;
    @(negedge clk);
    chk("R11 cs_n", cs_n, 1);
    chk("R11 sclk", sclk, 0);
    chk("R11 tx_full", tx_full, 0);
    chk("R11 rx_full", rx_full, 0);
    chk("R11 rx_ovf", rx_ovf, 0);
    chk("R8 eot after reset", eot, 0);
    chk("R10 irq_tx_empty idle", irq_tx_empty, 1);
    chk("R10 dma_wr_req idle", dma_wr_req, 1);
    idle_check("R1 no start without write", 40);

    exp_q.push_back(8'h00);
    mode = 2'b01;
    wait_done();
    chk("R7 rx word in receive-only", rx_data, slv_sent);
    chk("R7 rx_full", rx_full, 1);
    chk("R7 irq_tx_empty gated", irq_tx_empty, 0);
    chk("R7 dma_wr_req gated", dma_wr_req, 0);
    chk("R8 eot after completion", eot, 1);
    chk("R10 irq_rx_full", irq_rx_full, 1);
    idle_check("R7 hold while rx full", 60);

    mode = 2'b00;
    do_read();
    chk("R6 read clears rx_full", rx_full, 0);

    do_write(8'h3C);
    chk("R10 tx_full after write", tx_full, 1);
    chk("R10 irq_tx_empty after write", irq_tx_empty, 0);
    @(negedge clk);
    chk("R9 cs_n low at start", cs_n, 0);
    chk("R9 sclk still low", sclk, 0);
    chk("R8 eot cleared at start", eot, 0);
    @(negedge clk);
    chk("R9 first rising edge", sclk, 1);
    wait_done();
    chk("R1 master received word", rx_data, slv_sent);
    chk("R10 dma_rd_req", dma_rd_req, 1);
    held = rx_data;

    do_write(8'hC3);
    wait_done();
    chk("R6 overflow set", rx_ovf, 1);
    chk("R6 rx_data kept", rx_data, held);
    do_read();
    chk("R6 overflow cleared", rx_ovf, 0);
    chk("R6 rx_full cleared", rx_full, 0);

    mode = 2'b11;
    do_write(8'h81);
    wait_done();
    chk("R2 mode 11 acts as full duplex", rx_data, slv_sent);
    chk("R2 rx_full in mode 11", rx_full, 1);

    mode = 2'b10;
    idle_check("R3 no start before write", 60);
    chk("R5 irq_rx_full gated", irq_rx_full, 0);
    chk("R5 dma_rd_req gated", dma_rd_req, 0);
    do_write(8'h55);
    wait_done();
    chk("R4 overwrite while full", rx_data, slv_sent);
    chk("R4 no overflow", rx_ovf, 0);
    do_write(8'hAA);
    wait_done();
    chk("R4 second overwrite", rx_data, slv_sent);
    chk("R4 still no overflow", rx_ovf, 0);
    chk("R5 irq_rx_full still gated", irq_rx_full, 0);

    repeat (4) @(negedge clk);
    chk("R1 scoreboard drained", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule